// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Network

This block sits at the entry of the execute stage of a five-stage integer pipeline and repairs stale operands. Decode has already read the register file and captured five operand values: two ALU inputs, two branch-compare inputs and the store-data word. Older instructions further down the pipe may not yet have written their results back. The block compares each operand's source register with the destination fields of three producer latches and substitutes the newest matching result. The three latches are the execute/memory latch, the memory/writeback latch, and the latch that holds the instruction just written back.

Each producer supplies a general-register value. That value is the producer's load result when the producer is a load, and its ALU result otherwise. The block also forwards the two special multiply/divide registers, LO and HI, which come from the low and high halves of the producer's ALU result pair. A mode input selects full bypassing from all three latches or writeback-only bypassing. The second mode models a register file that is written in the first half of a cycle and read in the second. For every operand the block reports which stage supplied the final value. The logic is purely combinational.

Top module: `opnd_bypass_net`

## Requirements
- R1: An operand with no matching enabled producer leaves the block equal to its captured value, and its source flags are all zero.
- R2: A producer matches a read register when its rd-write flag is set and its rd field equals that register, or when its rt-write flag is set and its rt field equals that register.
- R3: Reading register 0 never forwards; the captured value and zero flags are kept, even if a producer targets register 0.
- R4: When several producers match, the execute/memory latch wins over the memory/writeback latch, which wins over the writeback latch.
- R5: A matching load producer supplies its load result. The execute/memory producer has no load result, so a matching load there supplies zero.
- R6: ALU port A with selector LO takes the low ALU half of a producer whose LO-write flag is set. With selector HI it takes the high half of a producer whose HI-write flag is set. Priority follows R4.
- R7: The ALU port A selector is coded 0 = captured, 1 = rs, 2 = rt, 3 = LO, 4 = HI; codes 5 to 7 act as 0. ALU port B and branch port B forward rt when their enable is set. Branch port A forwards rs when its enable is set. Store data forwards rt only when the store flag is set. A disabled port passes its captured value.
- R8: With the full-mode input low, only the writeback latch is considered; matches in the other two latches have no effect.
- R9: Each port's 3-bit source flag (bit 0 execute/memory, bit 1 memory/writeback, bit 2 writeback) is one-hot or zero, and names the stage whose value appears on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| full_mode_i | input | 1 | 1 = bypass from all three latches, 0 = writeback latch only |
| rs_idx_i | input | RAW | Consumer's rs register index |
| rt_idx_i | input | RAW | Consumer's rt register index |
| alu_a_sel_i | input | 3 | ALU port A source selector (see R7) |
| alu_b_rt_i | input | 1 | ALU port B reads rt |
| br_a_rs_i | input | 1 | Branch port A reads rs |
| br_b_rt_i | input | 1 | Branch port B reads rt |
| is_store_i | input | 1 | Consumer is a store |
| alu_a_cap_i | input | XLEN | Captured ALU port A value |
| alu_b_cap_i | input | XLEN | Captured ALU port B value |
| br_a_cap_i | input | XLEN | Captured branch port A value |
| br_b_cap_i | input | XLEN | Captured branch port B value |
| st_cap_i | input | XLEN | Captured store data |
| src_wr_rd_i | input | 3 | Per producer: writes rd (index 0 EX/MEM, 1 MEM/WB, 2 WB) |
| src_rd_i | input | 3xRAW | Per producer rd field |
| src_wr_rt_i | input | 3 | Per producer: writes rt |
| src_rt_i | input | 3xRAW | Per producer rt field |
| src_wr_lo_i | input | 3 | Per producer: writes LO |
| src_wr_hi_i | input | 3 | Per producer: writes HI |
| src_load_i | input | 3 | Per producer: is a load |
| src_res_lo_i | input | 3xXLEN | Per producer ALU result, low half |
| src_res_hi_i | input | 3xXLEN | Per producer ALU result, high half |
| mwb_ld_res_i | input | XLEN | Load result in the MEM/WB latch |
| wb_ld_res_i | input | XLEN | Load result in the writeback latch |
| alu_a_o | output | XLEN | Bypassed ALU port A |
| alu_b_o | output | XLEN | Bypassed ALU port B |
| br_a_o | output | XLEN | Bypassed branch port A |
| br_b_o | output | XLEN | Bypassed branch port B |
| st_o | output | XLEN | Bypassed store data |
| alu_a_src_o | output | 3 | ALU port A source flags |
| alu_b_src_o | output | 3 | ALU port B source flags |
| br_a_src_o | output | 3 | Branch port A source flags |
| br_b_src_o | output | 3 | Branch port B source flags |
| st_src_o | output | 3 | Store data source flags |

## Verification
The bench drives producers that all target the same register, which shows whether the priority is inverted and an older result wins. It matches register 0 through both the rd and rt fields; a design without the zero guard would overwrite the operand with garbage. It places loads in each latch and expects zero from the execute/memory load, a check that catches a design forwarding the ALU result there. It also sets up execute and memory hits in writeback-only mode, where a design that ignores the mode would raise the wrong flag. Random traffic uses a small register range, so multi-way matches and LO/HI selections occur often.

// File: rtl/opnd_bypass_pkg.sv
package opnd_bypass_pkg;
  localparam int unsigned NSRC   = 3;
  localparam int unsigned SRC_EX = 0;
  localparam int unsigned SRC_MEM = 1;
  localparam int unsigned SRC_WB = 2;

  localparam int unsigned NPORT  = 5;
  localparam int unsigned P_ALUA = 0;
  localparam int unsigned P_ALUB = 1;
  localparam int unsigned P_BRA  = 2;
  localparam int unsigned P_BRB  = 3;
  localparam int unsigned P_ST   = 4;

  typedef enum logic [2:0] {
    OPA_CAP = 3'd0,
    OPA_RS  = 3'd1,
    OPA_RT  = 3'd2,
    OPA_LO  = 3'd3,
    OPA_HI  = 3'd4
  } opa_sel_e;
endpackage

// File: rtl/opnd_bypass_src.sv
module opnd_bypass_src #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned RAW  = 5
) (
  input  logic            en_i,
  input  logic            wr_rd_i,
  input  logic [RAW-1:0]  rd_i,
  input  logic            wr_rt_i,
  input  logic [RAW-1:0]  rt_i,
  input  logic            wr_lo_i,
  input  logic            wr_hi_i,
  input  logic            load_i,
  input  logic [XLEN-1:0] res_lo_i,
  input  logic [XLEN-1:0] res_hi_i,
  input  logic [XLEN-1:0] ld_res_i,
  input  logic [RAW-1:0]  rs_idx_i,
  input  logic [RAW-1:0]  rt_idx_i,
  output logic            hit_rs_o,
  output logic            hit_rt_o,
  output logic            hit_lo_o,
  output logic            hit_hi_o,
  output logic [XLEN-1:0] gpr_val_o,
  output logic [XLEN-1:0] lo_val_o,
  output logic [XLEN-1:0] hi_val_o
);
  // a producer targets a register through either of its two destination fields
  function automatic logic targets(input logic [RAW-1:0] idx);
    logic via_rd, via_rt;
    via_rd = wr_rd_i && (rd_i == idx);
    via_rt = wr_rt_i && (rt_i == idx);
    return (idx != '0) && (via_rd || via_rt);
  endfunction

  always_comb begin
    hit_rs_o  = en_i && targets(rs_idx_i);
    hit_rt_o  = en_i && targets(rt_idx_i);
    hit_lo_o  = en_i && wr_lo_i;
    hit_hi_o  = en_i && wr_hi_i;
    gpr_val_o = load_i ? ld_res_i : res_lo_i;
    lo_val_o  = res_lo_i;
    hi_val_o  = res_hi_i;
  end
endmodule

// File: rtl/opnd_bypass_pick.sv
module opnd_bypass_pick #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NSRC = 3
) (
  input  logic [XLEN-1:0]            cap_i,
  input  logic [NSRC-1:0]            hit_i,
  input  logic [NSRC-1:0][XLEN-1:0]  val_i,
  output logic [XLEN-1:0]            val_o,
  output logic [NSRC-1:0]            src_o
);
  // index 0 is the youngest producer; walk oldest first so younger overrides
  always_comb begin
    val_o = cap_i;
    src_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        val_o = val_i[i];
        src_o = '0;
        src_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/opnd_bypass_net.sv
module opnd_bypass_net
  import opnd_bypass_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned RAW  = 5
) (
  input  logic                       full_mode_i,
  input  logic [RAW-1:0]             rs_idx_i,
  input  logic [RAW-1:0]             rt_idx_i,
  input  logic [2:0]                 alu_a_sel_i,
  input  logic                       alu_b_rt_i,
  input  logic                       br_a_rs_i,
  input  logic                       br_b_rt_i,
  input  logic                       is_store_i,
  input  logic [XLEN-1:0]            alu_a_cap_i,
  input  logic [XLEN-1:0]            alu_b_cap_i,
  input  logic [XLEN-1:0]            br_a_cap_i,
  input  logic [XLEN-1:0]            br_b_cap_i,
  input  logic [XLEN-1:0]            st_cap_i,
  input  logic [2:0]                 src_wr_rd_i,
  input  logic [2:0][RAW-1:0]        src_rd_i,
  input  logic [2:0]                 src_wr_rt_i,
  input  logic [2:0][RAW-1:0]        src_rt_i,
  input  logic [2:0]                 src_wr_lo_i,
  input  logic [2:0]                 src_wr_hi_i,
  input  logic [2:0]                 src_load_i,
  input  logic [2:0][XLEN-1:0]       src_res_lo_i,
  input  logic [2:0][XLEN-1:0]       src_res_hi_i,
  input  logic [XLEN-1:0]            mwb_ld_res_i,
  input  logic [XLEN-1:0]            wb_ld_res_i,
  output logic [XLEN-1:0]            alu_a_o,
  output logic [XLEN-1:0]            alu_b_o,
  output logic [XLEN-1:0]            br_a_o,
  output logic [XLEN-1:0]            br_b_o,
  output logic [XLEN-1:0]            st_o,
  output logic [2:0]                 alu_a_src_o,
  output logic [2:0]                 alu_b_src_o,
  output logic [2:0]                 br_a_src_o,
  output logic [2:0]                 br_b_src_o,
  output logic [2:0]                 st_src_o
);
  logic [NSRC-1:0][XLEN-1:0] ld_res;
  logic [NSRC-1:0]           hit_rs, hit_rt, hit_lo, hit_hi;
  logic [NSRC-1:0][XLEN-1:0] gpr_val, lo_val, hi_val;

  // the youngest latch cannot supply load data: a load-use stall covers it
  assign ld_res[SRC_EX]  = '0;
  assign ld_res[SRC_MEM] = mwb_ld_res_i;
  assign ld_res[SRC_WB]  = wb_ld_res_i;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic en;
    assign en = full_mode_i || (s == SRC_WB);
    opnd_bypass_src #(.XLEN(XLEN), .RAW(RAW)) u_src (
      .en_i      (en),
      .wr_rd_i   (src_wr_rd_i[s]),
      .rd_i      (src_rd_i[s]),
      .wr_rt_i   (src_wr_rt_i[s]),
      .rt_i      (src_rt_i[s]),
      .wr_lo_i   (src_wr_lo_i[s]),
      .wr_hi_i   (src_wr_hi_i[s]),
      .load_i    (src_load_i[s]),
      .res_lo_i  (src_res_lo_i[s]),
      .res_hi_i  (src_res_hi_i[s]),
      .ld_res_i  (ld_res[s]),
      .rs_idx_i  (rs_idx_i),
      .rt_idx_i  (rt_idx_i),
      .hit_rs_o  (hit_rs[s]),
      .hit_rt_o  (hit_rt[s]),
      .hit_lo_o  (hit_lo[s]),
      .hit_hi_o  (hit_hi[s]),
      .gpr_val_o (gpr_val[s]),
      .lo_val_o  (lo_val[s]),
      .hi_val_o  (hi_val[s])
    );
  end

  // per-port candidate hits and values
  logic [NPORT-1:0][XLEN-1:0]            cap;
  logic [NPORT-1:0][NSRC-1:0]            port_hit;
  logic [NPORT-1:0][NSRC-1:0][XLEN-1:0]  port_val;
  logic [NPORT-1:0][XLEN-1:0]            port_out;
  logic [NPORT-1:0][NSRC-1:0]            port_src;
  opa_sel_e                              a_sel;

  assign a_sel = opa_sel_e'(alu_a_sel_i);

  always_comb begin
    cap[P_ALUA] = alu_a_cap_i;
    cap[P_ALUB] = alu_b_cap_i;
    cap[P_BRA]  = br_a_cap_i;
    cap[P_BRB]  = br_b_cap_i;
    cap[P_ST]   = st_cap_i;

    unique case (a_sel)
      OPA_RS:  begin port_hit[P_ALUA] = hit_rs; port_val[P_ALUA] = gpr_val; end
      OPA_RT:  begin port_hit[P_ALUA] = hit_rt; port_val[P_ALUA] = gpr_val; end
      OPA_LO:  begin port_hit[P_ALUA] = hit_lo; port_val[P_ALUA] = lo_val;  end
      OPA_HI:  begin port_hit[P_ALUA] = hit_hi; port_val[P_ALUA] = hi_val;  end
      default: begin port_hit[P_ALUA] = '0;     port_val[P_ALUA] = gpr_val; end
    endcase

    port_hit[P_ALUB] = alu_b_rt_i ? hit_rt : '0;
    port_val[P_ALUB] = gpr_val;
    port_hit[P_BRA]  = br_a_rs_i  ? hit_rs : '0;
    port_val[P_BRA]  = gpr_val;
    port_hit[P_BRB]  = br_b_rt_i  ? hit_rt : '0;
    port_val[P_BRB]  = gpr_val;
    port_hit[P_ST]   = is_store_i ? hit_rt : '0;
    port_val[P_ST]   = gpr_val;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    opnd_bypass_pick #(.XLEN(XLEN), .NSRC(NSRC)) u_pick (
      .cap_i (cap[p]),
      .hit_i (port_hit[p]),
      .val_i (port_val[p]),
      .val_o (port_out[p]),
      .src_o (port_src[p])
    );
  end

  assign alu_a_o     = port_out[P_ALUA];
  assign alu_b_o     = port_out[P_ALUB];
  assign br_a_o      = port_out[P_BRA];
  assign br_b_o      = port_out[P_BRB];
  assign st_o        = port_out[P_ST];
  assign alu_a_src_o = port_src[P_ALUA];
  assign alu_b_src_o = port_src[P_ALUB];
  assign br_a_src_o  = port_src[P_BRA];
  assign br_b_src_o  = port_src[P_BRB];
  assign st_src_o    = port_src[P_ST];
endmodule

// File: rtl/opnd_bypass_chk.sv
module opnd_bypass_chk #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned RAW  = 5
) (
  input logic                 full_mode_i,
  input logic [RAW-1:0]       rt_idx_i,
  input logic [2:0]           alu_a_sel_i,
  input logic                 alu_b_rt_i,
  input logic                 is_store_i,
  input logic [2:0]           src_load_i,
  input logic [XLEN-1:0]      alu_a_cap_i,
  input logic [XLEN-1:0]      alu_b_cap_i,
  input logic [XLEN-1:0]      st_cap_i,
  input logic [XLEN-1:0]      alu_a_o,
  input logic [XLEN-1:0]      alu_b_o,
  input logic [XLEN-1:0]      st_o,
  input logic [2:0]           alu_a_src_o,
  input logic [2:0]           alu_b_src_o,
  input logic [2:0]           br_a_src_o,
  input logic [2:0]           br_b_src_o,
  input logic [2:0]           st_src_o
);
  always_comb begin
    p_flags_onehot_r9: assert ($onehot0(alu_a_src_o) && $onehot0(alu_b_src_o) &&
                               $onehot0(br_a_src_o) && $onehot0(br_b_src_o) &&
                               $onehot0(st_src_o))
      else $error("source flags not one-hot-or-zero");
    p_passthru_r1: assert ((alu_b_src_o != 3'b000) || (alu_b_o == alu_b_cap_i))
      else $error("unbypassed port B changed");
    p_wb_only_r8: assert (full_mode_i ||
                          ((alu_a_src_o[1:0] == 2'b00) && (alu_b_src_o[1:0] == 2'b00) &&
                           (br_a_src_o[1:0] == 2'b00) && (br_b_src_o[1:0] == 2'b00) &&
                           (st_src_o[1:0] == 2'b00)))
      else $error("young latch used in writeback-only mode");
    p_zero_reg_r3: assert (!(alu_b_rt_i && (rt_idx_i == '0)) || (alu_b_src_o == 3'b000))
      else $error("register 0 forwarded");
    p_store_gate_r7: assert (is_store_i || ((st_src_o == 3'b000) && (st_o == st_cap_i)))
      else $error("store data bypassed for non-store");
    p_ex_load_zero_r5: assert (!(alu_a_src_o[0] && src_load_i[0] &&
                                 ((alu_a_sel_i == 3'd1) || (alu_a_sel_i == 3'd2))) ||
                               (alu_a_o == '0))
      else $error("EX/MEM load forwarded non-zero");
    p_sel_idle_r7: assert (!((alu_a_sel_i == 3'd0) || (alu_a_sel_i > 3'd4)) ||
                           ((alu_a_src_o == 3'b000) && (alu_a_o == alu_a_cap_i)))
      else $error("port A bypassed with captured selector");
  end
endmodule

bind opnd_bypass_net opnd_bypass_chk #(.XLEN(XLEN), .RAW(RAW)) u_chk (
  .full_mode_i (full_mode_i),
  .rt_idx_i    (rt_idx_i),
  .alu_a_sel_i (alu_a_sel_i),
  .alu_b_rt_i  (alu_b_rt_i),
  .is_store_i  (is_store_i),
  .src_load_i  (src_load_i),
  .alu_a_cap_i (alu_a_cap_i),
  .alu_b_cap_i (alu_b_cap_i),
  .st_cap_i    (st_cap_i),
  .alu_a_o     (alu_a_o),
  .alu_b_o     (alu_b_o),
  .st_o        (st_o),
  .alu_a_src_o (alu_a_src_o),
  .alu_b_src_o (alu_b_src_o),
  .br_a_src_o  (br_a_src_o),
  .br_b_src_o  (br_b_src_o),
  .st_src_o    (st_src_o)
);

// File: tb/sim_opnd_bypass_net.sv
`timescale 1ns/1ps
module sim_opnd_bypass_net;
  localparam int XLEN = 32;
  localparam int RAW  = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                 full_mode;
  logic [RAW-1:0]       rs_idx, rt_idx;
  logic [2:0]           a_sel;
  logic                 b_rt, bra_rs, brb_rt, is_st;
  logic [XLEN-1:0]      cap_a, cap_b, cap_bra, cap_brb, cap_st;
  logic [2:0]           s_wrd, s_wrt, s_wlo, s_whi, s_ld;
  logic [2:0][RAW-1:0]  s_rd, s_rt;
  logic [2:0][XLEN-1:0] s_lo, s_hi;
  logic [XLEN-1:0]      ld_m, ld_w;

  logic [XLEN-1:0] o_a, o_b, o_bra, o_brb, o_st;
  logic [2:0]      f_a, f_b, f_bra, f_brb, f_st;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  opnd_bypass_net #(.XLEN(XLEN), .RAW(RAW)) u0 (
    .full_mode_i(full_mode), .rs_idx_i(rs_idx), .rt_idx_i(rt_idx),
    .alu_a_sel_i(a_sel), .alu_b_rt_i(b_rt), .br_a_rs_i(bra_rs), .br_b_rt_i(brb_rt),
    .is_store_i(is_st), .alu_a_cap_i(cap_a), .alu_b_cap_i(cap_b),
    .br_a_cap_i(cap_bra), .br_b_cap_i(cap_brb), .st_cap_i(cap_st),
    .src_wr_rd_i(s_wrd), .src_rd_i(s_rd), .src_wr_rt_i(s_wrt), .src_rt_i(s_rt),
    .src_wr_lo_i(s_wlo), .src_wr_hi_i(s_whi), .src_load_i(s_ld),
    .src_res_lo_i(s_lo), .src_res_hi_i(s_hi),
    .mwb_ld_res_i(ld_m), .wb_ld_res_i(ld_w),
    .alu_a_o(o_a), .alu_b_o(o_b), .br_a_o(o_bra), .br_b_o(o_brb), .st_o(o_st),
    .alu_a_src_o(f_a), .alu_b_src_o(f_b), .br_a_src_o(f_bra),
    .br_b_src_o(f_brb), .st_src_o(f_st)
  );

  // reference: general register read (R2, R3, R4, R5, R8)
  function automatic logic [XLEN-1:0] ref_gpr(input logic [RAW-1:0] idx,
                                              input logic [XLEN-1:0] cap,
                                              output logic [2:0] fl);
    logic [XLEN-1:0] v;
    v = cap; fl = 3'b000;
    for (int s = 2; s >= 0; s--) begin
      if ((full_mode || s == 2) && idx != 0 &&
          ((s_wrd[s] && s_rd[s] == idx) || (s_wrt[s] && s_rt[s] == idx))) begin
        if (s_ld[s]) v = (s == 0) ? '0 : (s == 1) ? ld_m : ld_w;
        else         v = s_lo[s];
        fl = 3'b001 << s;
      end
    end
    return v;
  endfunction

  // reference: LO / HI read (R6)
  function automatic logic [XLEN-1:0] ref_spec(input logic want_hi,
                                               input logic [XLEN-1:0] cap,
                                               output logic [2:0] fl);
    logic [XLEN-1:0] v;
    v = cap; fl = 3'b000;
    for (int s = 2; s >= 0; s--) begin
      if ((full_mode || s == 2) && (want_hi ? s_whi[s] : s_wlo[s])) begin
        v = want_hi ? s_hi[s] : s_lo[s];
        fl = 3'b001 << s;
      end
    end
    return v;
  endfunction

  task automatic cmp(input string tag, input string port,
                     input logic [XLEN-1:0] gv, input logic [XLEN-1:0] ev,
                     input logic [2:0] gf, input logic [2:0] ef);
    vectors++;
    if (gv !== ev || gf !== ef) begin
      errors++;
      $display("FAIL %s %s: got %h/%b expected %h/%b", tag, port, gv, gf, ev, ef);
    end
  endtask

  task automatic check_all(input string tag);
    logic [XLEN-1:0] ev;
    logic [2:0] ef;
    #1;
    case (a_sel)
      3'd1: ev = ref_gpr(rs_idx, cap_a, ef);
      3'd2: ev = ref_gpr(rt_idx, cap_a, ef);
      3'd3: ev = ref_spec(1'b0, cap_a, ef);
      3'd4: ev = ref_spec(1'b1, cap_a, ef);
      default: begin ev = cap_a; ef = 3'b000; end
    endcase
    cmp(tag, "alu_a", o_a, ev, f_a, ef);
    if (b_rt) ev = ref_gpr(rt_idx, cap_b, ef); else begin ev = cap_b; ef = 0; end
    cmp(tag, "alu_b", o_b, ev, f_b, ef);
    if (bra_rs) ev = ref_gpr(rs_idx, cap_bra, ef); else begin ev = cap_bra; ef = 0; end
    cmp(tag, "br_a", o_bra, ev, f_bra, ef);
    if (brb_rt) ev = ref_gpr(rt_idx, cap_brb, ef); else begin ev = cap_brb; ef = 0; end
    cmp(tag, "br_b", o_brb, ev, f_brb, ef);
    if (is_st) ev = ref_gpr(rt_idx, cap_st, ef); else begin ev = cap_st; ef = 0; end
    cmp(tag, "store", o_st, ev, f_st, ef);
  endtask

  task automatic clear_all();
    full_mode = 1'b1; rs_idx = '0; rt_idx = '0; a_sel = 3'd0;
    b_rt = 0; bra_rs = 0; brb_rt = 0; is_st = 0;
    cap_a = 32'hA0A0_0001; cap_b = 32'hB0B0_0002; cap_bra = 32'hC0C0_0003;
    cap_brb = 32'hD0D0_0004; cap_st = 32'hE0E0_0005;
    s_wrd = 0; s_wrt = 0; s_wlo = 0; s_whi = 0; s_ld = 0;
    s_rd = '0; s_rt = '0;
    s_lo[0] = 32'h1111_0000; s_lo[1] = 32'h2222_0000; s_lo[2] = 32'h3333_0000;
    s_hi[0] = 32'h1111_FFFF; s_hi[1] = 32'h2222_FFFF; s_hi[2] = 32'h3333_FFFF;
    ld_m = 32'h4444_4444; ld_w = 32'h5555_5555;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk); clear_all();
    b_rt = 1; bra_rs = 1; brb_rt = 1; is_st = 1; a_sel = 3'd1;
    rs_idx = 5'd7; rt_idx = 5'd9;
    // R1: no producer writes anything -> captured values, zero flags
    check_all("R1");
    #1;
    if (o_b !== cap_b || f_b !== 3'b000) begin
      errors++; $display("FAIL R1 direct: got %h/%b expected %h/000", o_b, f_b, cap_b);
    end
    vectors++;

    // R2: MEM/WB producer writes rt field = 9; WB writes rd = 7
    @(negedge clk); s_wrt[1] = 1; s_rt[1] = 5'd9; s_wrd[2] = 1; s_rd[2] = 5'd7;
    check_all("R2");
    if (o_b !== s_lo[1] || f_b !== 3'b010) begin
      errors++; $display("FAIL R2 direct: got %h/%b expected %h/010", o_b, f_b, s_lo[1]);
    end
    vectors++;

    // R3: register 0 read, producers target 0 via both fields
    @(negedge clk); clear_all(); b_rt = 1; is_st = 1; a_sel = 3'd1;
    s_wrd = 3'b111; s_wrt = 3'b111;
    check_all("R3");

    // R4: all three target register 5 -> EX/MEM wins, then MEM/WB
    @(negedge clk); clear_all(); rs_idx = 5'd5; rt_idx = 5'd5;
    a_sel = 3'd2; b_rt = 1; bra_rs = 1; brb_rt = 1; is_st = 1;
    s_wrd = 3'b111; s_rd[0] = 5'd5; s_rd[1] = 5'd5; s_rd[2] = 5'd5;
    check_all("R4");
    if (o_bra !== s_lo[0] || f_bra !== 3'b001) begin
      errors++; $display("FAIL R4 direct: got %h/%b expected %h/001", o_bra, f_bra, s_lo[0]);
    end
    vectors++;
    @(negedge clk); s_wrd[0] = 0; check_all("R4");

    // R5: load in MEM/WB -> load data; load in EX/MEM -> zero
    @(negedge clk); s_ld = 3'b110; check_all("R5");
    @(negedge clk); s_wrd[0] = 1; s_ld = 3'b111; check_all("R5");
    if (o_a !== 32'h0 || f_a !== 3'b001) begin
      errors++; $display("FAIL R5 direct: got %h/%b expected 00000000/001", o_a, f_a);
    end
    vectors++;

    // R6: LO from writeback, HI from EX/MEM over WB
    @(negedge clk); clear_all(); a_sel = 3'd3; s_wlo[2] = 1; check_all("R6");
    @(negedge clk); a_sel = 3'd4; s_whi = 3'b101; check_all("R6");
    if (o_a !== s_hi[0]) begin
      errors++; $display("FAIL R6 direct: got %h expected %h", o_a, s_hi[0]);
    end
    vectors++;

    // R7: ports disabled / non-store / idle selector codes
    @(negedge clk); clear_all(); rs_idx = 5'd3; rt_idx = 5'd3;
    s_wrd = 3'b111; s_rd[0] = 5'd3; s_rd[1] = 5'd3; s_rd[2] = 5'd3;
    for (int c = 0; c < 8; c++) begin
      a_sel = 3'(c); check_all("R7"); @(negedge clk);
    end

    // R8: writeback-only mode ignores younger matches
    full_mode = 0; a_sel = 3'd1; b_rt = 1; bra_rs = 1; brb_rt = 1; is_st = 1;
    check_all("R8");
    @(negedge clk); s_wrd[2] = 0; check_all("R8");

    // R9 and all: random traffic over a small register range
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      full_mode = ($urandom % 4) != 0;
      rs_idx = 5'($urandom % 4); rt_idx = 5'($urandom % 4);
      a_sel = 3'($urandom); b_rt = 1'($urandom); bra_rs = 1'($urandom);
      brb_rt = 1'($urandom); is_st = 1'($urandom);
      cap_a = $urandom; cap_b = $urandom; cap_bra = $urandom;
      cap_brb = $urandom; cap_st = $urandom;
      s_wrd = 3'($urandom); s_wrt = 3'($urandom); s_wlo = 3'($urandom);
      s_whi = 3'($urandom); s_ld = 3'($urandom);
      for (int s = 0; s < 3; s++) begin
        s_rd[s] = 5'($urandom % 4); s_rt[s] = 5'($urandom % 4);
        s_lo[s] = $urandom; s_hi[s] = $urandom;
      end
      ld_m = $urandom; ld_w = $urandom;
      check_all("R9");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule